// File: doc/BRIEF.md
# Ring-Descriptor Write DMA Channel

This block is the destination half of a memory-to-memory copy engine. It takes a byte stream from an upstream FIFO and stores it into memory buffers. A circular chain of three-word descriptors in the same memory describes those buffers. Each descriptor holds a control word, a buffer byte address and the address of the next descriptor. Software fills the ring and points the channel at its first entry. It then starts the channel and later collects closed descriptors by following the reported end-of-packet descriptor address.

For every descriptor, the channel reads the three words and checks the control word. It then writes incoming bytes to consecutive byte addresses of the buffer until the buffer is full or a byte marked last arrives. At that point it rewrites the control word with the stored length, an end-of-packet flag and a cleared ownership bit. Only after that write has been accepted does it signal the software side. A descriptor owned by software (when ownership checking is on) or a descriptor with a zero size parks the channel until a restart or start pulse arrives.

The byte input is a valid/ready stream. Upstream must hold `in_valid`, `in_data` and `in_last` stable until `in_ready` is seen. `in_ready` rises only while the channel is in its fill phase and the memory port accepts the byte write in the same cycle, so memory stalls propagate straight back to the FIFO. The memory port is a request/grant interface with one read outstanding at a time. Read data returns on a later cycle flagged by `mem_rvalid`.

Top module: `wrdma_chan`

## Requirements
- R1: During reset and until the first start pulse, `mem_req`, `in_ready`, every event output and `eof_desc_addr` are zero.
- R2: A start pulse in idle or parked state loads `base_addr` as the current descriptor. The channel then reads the words at offsets 0, 4 and 8 from it, in that order. Start pulses at other times are ignored.
- R3: Each accepted input byte is written as a single-byte write. The write goes to byte address (buffer pointer + bytes already stored in this descriptor), with `mem_be` one-hot at the byte lane given by address bits [1:0] and the byte copied on all four lanes of `mem_wdata`. A byte is popped only in the cycle its write is granted.
- R4: The control word layout is: size in [11:0], length in [23:12], bits [27:24] and [29] preserved, error in [28], end-of-packet in [30], owner in [31] (1 = channel, 0 = software). When a buffer fills without a last byte, the channel writes back length = size, end-of-packet 0 and owner 0, and raises only `ev_done`. It then follows the next pointer.
- R5: When a byte carrying `in_last` is stored, the channel writes back length = bytes stored (including the case length = size), end-of-packet 1 and owner 0. It raises `ev_done` and `ev_eof` together.
- R6: At each end-of-packet event, `eof_desc_addr` holds the address of the descriptor just closed with end-of-packet, and keeps it until the next one.
- R7: With `check_owner` high, a control word whose owner bit is 0 raises `ev_desc_empty` for one cycle. The channel then makes no memory access and pops nothing until restart, start or stop. Restart re-reads the same descriptor. With `check_owner` low, the owner bit is not examined.
- R8: A control word with size 0 (owner check passed) raises `ev_desc_err` and parks the channel exactly as in R7. The descriptor is not written.
- R9: Events are single-cycle pulses, at most one of `ev_done`, `ev_desc_err` and `ev_desc_empty` at a time. `ev_done` is raised in the cycle after the granted write-back of that descriptor's control word.
- R10: A stop pulse returns the channel to idle at the next point where no memory access is outstanding. Restart in idle is ignored, and a following start reloads `base_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: load base address and begin |
| stop | input | 1 | Pulse: return to idle |
| restart | input | 1 | Pulse: re-read the current descriptor when parked |
| check_owner | input | 1 | Enable the ownership test on fetched descriptors |
| base_addr | input | AW | Address of the first descriptor |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the packet |
| in_ready | output | 1 | Input byte accepted this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ev_done | output | 1 | A descriptor was closed |
| ev_eof | output | 1 | The closed descriptor ended a packet |
| ev_desc_err | output | 1 | Descriptor with zero size fetched |
| ev_desc_empty | output | 1 | Descriptor owned by software fetched |
| eof_desc_addr | output | AW | Address of the last end-of-packet descriptor |

## Verification
A wrong byte counter shows up within one byte, because the next write lands on the wrong address or lane. It then shows at the descriptor close as a wrong length or a close at the wrong byte. A stale current-descriptor or next-pointer register becomes visible at the following fetch: the next read goes to an unexpected address, or an event is reported against a descriptor other than the one the model predicts. A lost park state shows up at the ports in the very next cycles as memory requests or byte pops while the ring is empty.

// File: rtl/wrdma_pkg.sv
package wrdma_pkg;
  localparam int LEN_W    = 12;
  localparam int OWN_BIT  = 31;
  localparam int EOF_BIT  = 30;
  localparam int ERR_BIT  = 28;
  localparam int DESC_WDS = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RDREQ,
    S_RDWAIT,
    S_DATA,
    S_WB,
    S_PARK
  } wr_state_e;
endpackage

// File: rtl/wrdma_desc_hold.sv
module wrdma_desc_hold
  import wrdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [1:0]  idx,
  input  logic [31:0] word,
  output logic [31:0] ctrl_w,
  output logic [31:0] buf_w,
  output logic [31:0] next_w
);
  logic [31:0] slot [DESC_WDS];

  for (genvar i = 0; i < DESC_WDS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        slot[i] <= '0;
      else if (load && idx == 2'(i))     slot[i] <= word;
    end
  end

  assign ctrl_w = slot[0];
  assign buf_w  = slot[1];
  assign next_w = slot[2];
endmodule

// File: rtl/wrdma_evt.sv
module wrdma_evt #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_done,
  input  logic          fire_eof,
  input  logic          fire_err,
  input  logic          fire_empty,
  input  logic [AW-1:0] at_addr,
  output logic          ev_done,
  output logic          ev_eof,
  output logic          ev_desc_err,
  output logic          ev_desc_empty,
  output logic [AW-1:0] eof_desc_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_done       <= 1'b0;
      ev_eof        <= 1'b0;
      ev_desc_err   <= 1'b0;
      ev_desc_empty <= 1'b0;
      eof_desc_addr <= '0;
    end else begin
      ev_done       <= fire_done;
      ev_eof        <= fire_eof;
      ev_desc_err   <= fire_err;
      ev_desc_empty <= fire_empty;
      if (fire_eof) eof_desc_addr <= at_addr;
    end
  end
endmodule

// File: rtl/wrdma_chan.sv
module wrdma_chan
  import wrdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          restart,
  input  logic          check_owner,
  input  logic [AW-1:0] base_addr,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          ev_done,
  output logic          ev_eof,
  output logic          ev_desc_err,
  output logic          ev_desc_empty,
  output logic [AW-1:0] eof_desc_addr
);
  wr_state_e        state;
  logic [AW-1:0]    cur;
  logic [1:0]       idx;
  logic [LEN_W-1:0] cnt;
  logic             eof_r;
  logic             stop_pend;

  logic [31:0]      ctrl_w, buf_w, next_w;
  logic [AW-1:0]    byte_addr;
  logic [31:0]      wb_word;
  logic             rd_load, own_block, size_bad, pop, cnt_full;
  logic             fire_done, fire_err, fire_empty;

  assign rd_load   = (state == S_RDWAIT) && mem_rvalid;
  assign own_block = check_owner && !mem_rdata[OWN_BIT];
  assign size_bad  = (mem_rdata[LEN_W-1:0] == '0);
  assign pop       = in_valid && in_ready;
  assign cnt_full  = (cnt + 1'b1) == ctrl_w[LEN_W-1:0];
  assign byte_addr = buf_w[AW-1:0] + AW'(cnt);
  assign wb_word   = {1'b0, eof_r, ctrl_w[29], 1'b0, ctrl_w[27:24], cnt, ctrl_w[LEN_W-1:0]};

  assign fire_done  = (state == S_WB) && mem_gnt;
  assign fire_empty = rd_load && (idx == 2'd0) && own_block;
  assign fire_err   = rd_load && (idx == 2'd0) && !own_block && size_bad;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_be    = 4'h0;
    mem_wdata = '0;
    in_ready  = 1'b0;
    unique case (state)
      S_RDREQ: begin
        mem_req  = !stop_pend;
        mem_addr = cur + AW'({idx, 2'b00});
      end
      S_DATA: begin
        mem_req   = in_valid && !stop_pend;
        mem_we    = 1'b1;
        mem_addr  = {byte_addr[AW-1:2], 2'b00};
        mem_be    = 4'b0001 << byte_addr[1:0];
        mem_wdata = {4{in_data}};
        in_ready  = mem_gnt && !stop_pend;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'hF;
        mem_wdata = wb_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur       <= '0;
      idx       <= '0;
      cnt       <= '0;
      eof_r     <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      if (state == S_IDLE) stop_pend <= 1'b0;
      else if (stop)       stop_pend <= 1'b1;
      unique case (state)
        S_IDLE: if (start) begin
          cur   <= base_addr;
          idx   <= '0;
          state <= S_RDREQ;
        end
        S_RDREQ: begin
          if (stop_pend)    state <= S_IDLE;
          else if (mem_gnt) state <= S_RDWAIT;
        end
        S_RDWAIT: if (mem_rvalid) begin
          if (idx == 2'd0 && (own_block || size_bad)) state <= S_PARK;
          else if (idx == 2'(DESC_WDS - 1)) begin
            cnt   <= '0;
            state <= S_DATA;
          end else begin
            idx   <= idx + 2'd1;
            state <= S_RDREQ;
          end
        end
        S_DATA: begin
          if (stop_pend) state <= S_IDLE;
          else if (pop) begin
            cnt <= cnt + 1'b1;
            if (in_last || cnt_full) begin
              eof_r <= in_last;
              state <= S_WB;
            end
          end
        end
        S_WB: if (mem_gnt) begin
          cur   <= next_w[AW-1:0];
          idx   <= '0;
          state <= S_RDREQ;
        end
        S_PARK: begin
          if (stop_pend) state <= S_IDLE;
          else if (start) begin
            cur   <= base_addr;
            idx   <= '0;
            state <= S_RDREQ;
          end else if (restart) begin
            idx   <= '0;
            state <= S_RDREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wrdma_desc_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (rd_load),
    .idx    (idx),
    .word   (mem_rdata),
    .ctrl_w (ctrl_w),
    .buf_w  (buf_w),
    .next_w (next_w)
  );

  wrdma_evt #(.AW(AW)) u_evt (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire_done     (fire_done),
    .fire_eof      (fire_done && eof_r),
    .fire_err      (fire_err),
    .fire_empty    (fire_empty),
    .at_addr       (cur),
    .ev_done       (ev_done),
    .ev_eof        (ev_eof),
    .ev_desc_err   (ev_desc_err),
    .ev_desc_empty (ev_desc_empty),
    .eof_desc_addr (eof_desc_addr)
  );
endmodule

// File: rtl/wrdma_chan_chk.sv
module wrdma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          ev_done,
  input logic          ev_eof,
  input logic          ev_desc_err,
  input logic          ev_desc_empty,
  input logic [AW-1:0] eof_desc_addr
);
  AST_POP_IS_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> mem_req && mem_we && mem_gnt && $countones(mem_be) == 1); // R3

  AST_EVENT_AFTER_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |-> $past(mem_req && mem_gnt && mem_we && mem_be == 4'hF)); // R9

  AST_EOF_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eof |-> ev_done); // R5

  AST_EOF_ADDR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eof |-> eof_desc_addr == $past(mem_addr)); // R6

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_done, ev_desc_err, ev_desc_empty}) <= 1); // R9

  AST_EMPTY_PARKS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_empty |-> !mem_req && !in_ready); // R7

  AST_EMPTY_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_empty |=> !ev_desc_empty); // R7

  AST_ERR_PARKS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_err |-> !mem_req && !in_ready); // R8
endmodule

bind wrdma_chan wrdma_chan_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_wrdma_chan.sv
module sim_wrdma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, stop = 0, restart = 0, check_owner = 1;
  logic [31:0] base_addr = 32'h0;
  logic        in_valid = 0, in_last = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready, mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, eof_desc_addr;
  logic [3:0]  mem_be;
  logic        ev_done, ev_eof, ev_desc_err, ev_desc_empty;

  always #10 clk = ~clk;

  wrdma_chan #(.AW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .restart(restart),
    .check_owner(check_owner), .base_addr(base_addr),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ev_done(ev_done), .ev_eof(ev_eof), .ev_desc_err(ev_desc_err),
    .ev_desc_empty(ev_desc_empty), .eof_desc_addr(eof_desc_addr)
  );

  int nchk = 0, nbad = 0, pop_cnt = 0, cyc = 0;
  logic [31:0] mem [0:255];
  logic [7:0]  lfsr = 8'hA5;
  logic        wbp_v = 0;
  logic [31:0] wbp_a = 0;
  logic [31:0] rd_log [$];
  int          exp_kind [$];
  logic [31:0] exp_addr [$];
  bit          done_flag = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: grant ~75% of cycles, read data one cycle after grant
  assign mem_gnt = lfsr[0] | lfsr[1];
  always @(posedge clk) begin
    lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rvalid <= 1'b0;
    wbp_v      <= mem_req && mem_gnt && mem_we && mem_be == 4'hF;
    wbp_a      <= mem_addr;
    if (in_valid && in_ready) pop_cnt <= pop_cnt + 1;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[9:2]];
        rd_log.push_back(mem_addr);
      end
    end
  end

  // per-clock comparison of events against the predicted sequence
  always @(negedge clk) begin
    if (rst_n && (ev_done || ev_desc_err || ev_desc_empty)) begin
      int kind;
      kind = ev_desc_empty ? 4 : ev_desc_err ? 3 : ev_eof ? 2 : 1;
      if (exp_kind.size() == 0) chk(0, "R9", "unexpected event", kind, 0);
      else begin
        int k;
        logic [31:0] a;
        k = exp_kind.pop_front();
        a = exp_addr.pop_front();
        chk(kind == k, "R4", "event kind", kind, k);
        if (kind <= 2) chk(wbp_v && wbp_a == a, "R9", "write-back address just before event", wbp_a, a);
        if (kind == 2) chk(eof_desc_addr == a, "R6", "eof descriptor address", eof_desc_addr, a);
      end
    end
    if (rst_n && in_valid && in_ready)
      chk(mem_we && mem_wdata[7:0] == in_data && $countones(mem_be) == 1, "R3", "pop without byte write", mem_be, 1);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1;
      nchk++; nbad++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  function automatic logic [31:0] w0(bit own, bit eof, int len, int size);
    return {own, eof, 6'b0, len[11:0], size[11:0]};
  endfunction

  task automatic set_desc(int a, bit own, int size, int bufp, int nxt);
    mem[a/4]     = w0(own, 1'b0, 0, size);
    mem[a/4 + 1] = bufp;
    mem[a/4 + 2] = nxt;
  endtask

  function automatic logic [7:0] rdb(int a);
    return mem[a/4][8*(a%4) +: 8];
  endfunction

  task automatic expect_ev(int kind, logic [31:0] a);
    exp_kind.push_back(kind);
    exp_addr.push_back(a);
  endtask

  task automatic wait_drain(string req);
    int t = 0;
    while (exp_kind.size() != 0 && t < 3000) begin @(negedge clk); t++; end
    chk(exp_kind.size() == 0, req, "predicted events outstanding", exp_kind.size(), 0);
  endtask

  task automatic send(int n, logic [7:0] v0);
    for (int k = 0; k < n; k++) begin
      int c, t;
      in_valid = 1; in_data = v0 + 8'(k); in_last = (k == n - 1);
      c = pop_cnt; t = 0;
      while (pop_cnt == c && t < 2000) begin @(negedge clk); t++; end
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic pulse_start();   start = 1;   @(negedge clk); start = 0;   endtask
  task automatic pulse_stop();    stop = 1;    @(negedge clk); stop = 0;    endtask
  task automatic pulse_restart(); restart = 1; @(negedge clk); restart = 0; endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    set_desc(32'h00, 1, 4, 32'h100, 32'h0C);
    set_desc(32'h0C, 1, 4, 32'h141, 32'h18);
    set_desc(32'h18, 1, 8, 32'h180, 32'h00);
    repeat (4) @(negedge clk);
    chk(!mem_req && !in_ready, "R1", "request/ready in reset", {mem_req, in_ready}, 0);
    chk(!(ev_done | ev_eof | ev_desc_err | ev_desc_empty) && eof_desc_addr == 0, "R1",
        "events/eof address in reset", eof_desc_addr, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!mem_req && !in_ready, "R1", "idle before start", mem_req, 0);

    // packet of 10 bytes across sizes 4,4,8 (second buffer unaligned)
    expect_ev(1, 32'h00); expect_ev(1, 32'h0C); expect_ev(2, 32'h18); expect_ev(4, 32'h00);
    rd_log.delete();
    pulse_start();
    send(10, 8'h10);
    wait_drain("R5");
    chk(rd_log.size() >= 3 && rd_log[0] == 32'h00 && rd_log[1] == 32'h04 && rd_log[2] == 32'h08,
        "R2", "first descriptor fetch order", rd_log[1], 32'h04);
    chk(mem[0] == w0(0, 0, 4, 4), "R4", "full buffer close d0", mem[0], w0(0, 0, 4, 4));
    chk(mem[3] == w0(0, 0, 4, 4), "R4", "full buffer close d1", mem[3], w0(0, 0, 4, 4));
    chk(mem[6] == w0(0, 1, 2, 8), "R5", "eof close d2", mem[6], w0(0, 1, 2, 8));
    chk(eof_desc_addr == 32'h18, "R6", "eof address held", eof_desc_addr, 32'h18);
    for (int k = 0; k < 4; k++) begin
      chk(rdb(32'h100 + k) == 8'h10 + 8'(k), "R3", "buffer0 byte", rdb(32'h100 + k), 8'h10 + k);
      chk(rdb(32'h141 + k) == 8'h14 + 8'(k), "R3", "buffer1 byte", rdb(32'h141 + k), 8'h14 + k);
    end
    chk(rdb(32'h180) == 8'h18 && rdb(32'h181) == 8'h19 && rdb(32'h182) == 8'h00, "R3",
        "buffer2 bytes", rdb(32'h182), 0);

    // parked on a software-owned descriptor: offered data must not be taken
    begin
      int c;
      c = pop_cnt;
      in_valid = 1; in_data = 8'hEE;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (mem_req) chk(0, "R7", "memory access while parked", mem_req, 0);
      end
      chk(pop_cnt == c, "R7", "pops while parked", pop_cnt - c, 0);
      in_valid = 0;
    end

    // hand d0 back with size 3, d1 becomes malformed (size 0); restart
    mem[0] = w0(1, 0, 0, 3);
    mem[3] = w0(1, 0, 0, 0);
    expect_ev(2, 32'h00); expect_ev(3, 32'h0C);
    rd_log.delete();
    pulse_restart();
    send(3, 8'h30);
    wait_drain("R8");
    chk(rd_log.size() >= 1 && rd_log[0] == 32'h00, "R7", "restart re-reads same descriptor", rd_log[0], 0);
    chk(mem[0] == w0(0, 1, 3, 3), "R5", "last byte on exact fill", mem[0], w0(0, 1, 3, 3));
    chk(eof_desc_addr == 32'h00, "R6", "eof address updated", eof_desc_addr, 0);
    chk(mem[3] == w0(1, 0, 0, 0), "R8", "malformed descriptor untouched", mem[3], w0(1, 0, 0, 0));
    chk(rdb(32'h100) == 8'h30 && rdb(32'h102) == 8'h32 && rdb(32'h103) == 8'h13, "R3",
        "refill bytes", rdb(32'h102), 8'h32);

    // stop while parked, restart in idle must do nothing
    pulse_stop();
    repeat (4) @(negedge clk);
    rd_log.delete();
    pulse_restart();
    repeat (10) @(negedge clk);
    chk(rd_log.size() == 0 && !mem_req, "R10", "restart ignored in idle", rd_log.size(), 0);

    // owner check off: reuse a software-owned descriptor at a new base
    check_owner = 0;
    base_addr = 32'h18;
    expect_ev(2, 32'h18);
    rd_log.delete();
    pulse_start();
    send(5, 8'h50);
    wait_drain("R7");
    chk(rd_log.size() >= 3 && rd_log[0] == 32'h18 && rd_log[1] == 32'h1C && rd_log[2] == 32'h20,
        "R2", "fetch from reloaded base", rd_log[0], 32'h18);
    chk(mem[6] == w0(0, 1, 5, 8), "R7", "software-owned descriptor used", mem[6], w0(0, 1, 5, 8));
    chk(eof_desc_addr == 32'h18, "R6", "eof address", eof_desc_addr, 32'h18);
    chk(rdb(32'h180) == 8'h50 && rdb(32'h184) == 8'h54, "R3", "bytes at reloaded base", rdb(32'h184), 8'h54);
    repeat (40) @(negedge clk);
    chk(rd_log.size() == 6, "R7", "next owner-0 descriptor fetched without park", rd_log.size(), 6);

    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule